// File: doc/BRIEF.md
# Zero-Offset and Direction Position Shaper

This block builds an absolute single-turn position from a coarse track code and an interpolated fine code. The fine code sits below the coarse bits. The block subtracts a user zero point from that position, can reverse the counting direction, and hands the result to a serial transmitter as a registered Gray code word with a one-cycle valid flag.

A zero request arrives as an active-low level from an external pin. It is synchronized and edge-detected. After a falling edge, the next accepted position sample becomes the new zero point, and that sample is itself reported as zero. Every later sample is reported relative to that zero. The zero point sits in an ordinary register that resets to zero, so an external store could restore it.

Top module: `pos_offset_dir`

## Requirements
- R1: The raw position is {coarse_i, fine_i}: coarse_i occupies bits 16:4 and fine_i occupies bits 3:0. With a zero point of 0 and dir_inv_i low, the output is the Gray code of the raw position.
- R2: Once a falling edge of zero_req_ni has passed the synchronizer (at most 4 clock cycles), the next sample accepted with valid_i high is stored as the zero point, and that sample is output as 0.
- R3: Every sample after a capture is output as (raw − zero point) mod 2^17.
- R4: Holding zero_req_ni low captures only once. A new capture needs zero_req_ni high for at least 4 cycles and then a new fall.
- R5: When dir_inv_i is high in the same cycle as a sample, that sample is output as (2^17 − relative) mod 2^17, so a relative value of 0 stays 0.
- R6: The output word is g = b XOR (b >> 1), where b is the binary relative position.
- R7: valid_o is high for exactly one cycle, two clock cycles after valid_i was sampled high. gray_o holds its value while valid_o is low.
- R8: After reset, gray_o is 0, valid_o is 0 and the zero point is 0.
- R9: When the raw position is below the zero point, the difference wraps modulo 2^17. For example, raw 0 with zero point 1 gives binary 0x1FFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| coarse_i | input | 13 | Coarse absolute track code |
| fine_i | input | 4 | Interpolated fine code |
| valid_i | input | 1 | Sample strobe for coarse_i and fine_i |
| zero_req_ni | input | 1 | Zero request, active low, asynchronous |
| dir_inv_i | input | 1 | Reverse the counting direction when high |
| gray_o | output | 17 | Gray-coded relative position |
| valid_o | output | 1 | gray_o holds a new sample |

## Verification
Directed vectors check each piece of the function on its own:
- Samples with no zero point separate the bit packing and the Gray conversion from the offset path.
- A capture followed by positions above and below the zero point shows whether the subtraction and its modulo wrap are right.
- Holding the request low over two samples, then releasing it and pulling it low again, shows the difference between level-triggered and edge-triggered capture.
- Samples with the direction reversed, including a relative value of 0, show that negation is done modulo 2^17 and not as a bitwise invert.

Seeded random samples then mix direction changes with occasional zero requests, so these paths are exercised together.

// File: rtl/pos_pkg.sv
package pos_pkg;
  parameter int unsigned COARSE_W_DEF = 13;
  parameter int unsigned FINE_W_DEF   = 4;
  parameter int unsigned SYNC_N_DEF   = 2;
endpackage

// File: rtl/zero_req_edge.sv
// Synchronize the active-low zero request and emit one pulse per falling edge.
module zero_req_edge #(
  parameter int unsigned SYNC_N = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_ni,
  output logic fall_o
);
  // Stages 0..SYNC_N-1 form the synchronizer; stage SYNC_N holds the previous value.
  logic [SYNC_N:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '1;
    else         sync_q <= {sync_q[SYNC_N-1:0], req_ni};
  end

  assign fall_o = sync_q[SYNC_N] & ~sync_q[SYNC_N-1];
endmodule

// File: rtl/pos_rel_calc.sv
// Remove the zero point, apply the direction, and register the binary result.
module pos_rel_calc #(
  parameter int unsigned POS_W = 17
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic [POS_W-1:0] raw_i,
  input  logic             fall_i,
  input  logic             dir_inv_i,
  output logic [POS_W-1:0] bin_o,
  output logic             valid_o,
  output logic             capture_o,
  output logic [POS_W-1:0] preset_o
);
  logic             pending_q;
  logic [POS_W-1:0] preset_q;
  logic [POS_W-1:0] preset_eff;
  logic [POS_W-1:0] rel;
  logic [POS_W-1:0] dir_pos;

  assign capture_o  = valid_i & (pending_q | fall_i);
  assign preset_eff = capture_o ? raw_i : preset_q;
  assign rel        = raw_i - preset_eff;
  assign dir_pos    = dir_inv_i ? ('0 - rel) : rel;
  assign preset_o   = preset_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pending_q <= 1'b0;
      preset_q  <= '0;
      bin_o     <= '0;
      valid_o   <= 1'b0;
    end else begin
      pending_q <= (pending_q | fall_i) & ~valid_i;
      valid_o   <= valid_i;
      if (capture_o) preset_q <= raw_i;
      if (valid_i)   bin_o    <= dir_pos;
    end
  end
endmodule

// File: rtl/gray_enc_stage.sv
// Registered binary-to-Gray conversion.
module gray_enc_stage #(
  parameter int unsigned W = 17
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         valid_i,
  input  logic [W-1:0] bin_i,
  output logic [W-1:0] gray_o,
  output logic         valid_o
);
  logic [W-1:0] gray_d;

  for (genvar i = 0; i < W; i++) begin : g_bit
    if (i == W - 1) begin : g_top
      assign gray_d[i] = bin_i[i];
    end else begin : g_low
      assign gray_d[i] = bin_i[i] ^ bin_i[i+1];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gray_o  <= '0;
      valid_o <= 1'b0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) gray_o <= gray_d;
    end
  end
endmodule

// File: rtl/pos_offset_dir.sv
module pos_offset_dir
  import pos_pkg::*;
#(
  parameter int unsigned COARSE_W = COARSE_W_DEF,
  parameter int unsigned FINE_W   = FINE_W_DEF,
  parameter int unsigned SYNC_N   = SYNC_N_DEF,
  localparam int unsigned POS_W   = COARSE_W + FINE_W
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [COARSE_W-1:0] coarse_i,
  input  logic [FINE_W-1:0]   fine_i,
  input  logic                valid_i,
  input  logic                zero_req_ni,
  input  logic                dir_inv_i,
  output logic [POS_W-1:0]    gray_o,
  output logic                valid_o
);
  logic             zero_fall;
  logic             capture;
  logic [POS_W-1:0] preset;
  logic [POS_W-1:0] bin;
  logic             bin_vld;

  zero_req_edge #(.SYNC_N(SYNC_N)) u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .req_ni (zero_req_ni),
    .fall_o (zero_fall)
  );

  pos_rel_calc #(.POS_W(POS_W)) u_rel (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .valid_i   (valid_i),
    .raw_i     ({coarse_i, fine_i}),
    .fall_i    (zero_fall),
    .dir_inv_i (dir_inv_i),
    .bin_o     (bin),
    .valid_o   (bin_vld),
    .capture_o (capture),
    .preset_o  (preset)
  );

  gray_enc_stage #(.W(POS_W)) u_gray (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (bin_vld),
    .bin_i   (bin),
    .gray_o  (gray_o),
    .valid_o (valid_o)
  );
endmodule

// File: rtl/pos_offset_dir_chk.sv
module pos_offset_dir_chk #(
  parameter int unsigned POS_W = 17
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             valid_i,
  input logic             zero_fall,
  input logic             capture,
  input logic [POS_W-1:0] preset,
  input logic [POS_W-1:0] gray_o,
  input logic             valid_o
);
  assert_valid_lat_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> ##1 valid_o);
  assert_valid_quiet_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> ##1 !valid_o);
  assert_gray_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> $stable(gray_o));
  assert_zero_out_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    capture |=> ##1 (gray_o == '0));
  assert_preset_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !capture |=> $stable(preset));
  assert_single_edge_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    zero_fall |=> !zero_fall);
endmodule

bind pos_offset_dir pos_offset_dir_chk #(.POS_W(POS_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .valid_i   (valid_i),
  .zero_fall (zero_fall),
  .capture   (capture),
  .preset    (preset),
  .gray_o    (gray_o),
  .valid_o   (valid_o)
);

// File: tb/pos_offset_dir_tb_top.sv
`timescale 1ns/1ps
module pos_offset_dir_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [12:0] coarse = '0;
  logic [3:0]  fine = '0;
  logic        valid = 1'b0;
  logic        zreq_n = 1'b1;
  logic        dir = 1'b0;
  logic [16:0] gray;
  logic        vout;

  int checks = 0;
  int fails  = 0;
  logic [16:0] preset_m = '0;
  bit          pend_m = 1'b0;

  always #2 clk = ~clk;

  pos_offset_dir dut_i (
    .clk_i(clk), .rst_ni(rst_n), .coarse_i(coarse), .fine_i(fine),
    .valid_i(valid), .zero_req_ni(zreq_n), .dir_inv_i(dir),
    .gray_o(gray), .valid_o(vout)
  );

  function automatic logic [16:0] to_gray(input logic [16:0] b);
    return b ^ (b >> 1);
  endfunction

  task automatic chk(input bit ok, input string req, input logic [16:0] act, input logic [16:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic apply(input logic [12:0] c, input logic [3:0] f, input logic d, input string req);
    logic [16:0] raw;
    logic [16:0] rel;
    logic [16:0] eb;
    raw = {c, f};
    if (pend_m) begin preset_m = raw; pend_m = 1'b0; end
    rel = raw - preset_m;
    eb  = d ? (17'd0 - rel) : rel;
    coarse = c; fine = f; dir = d; valid = 1'b1;
    @(negedge clk); valid = 1'b0;
    @(negedge clk);
    chk(vout === 1'b1 && gray === to_gray(eb), req, {vout, gray[15:0]}, {1'b1, to_gray(eb)});
    @(negedge clk);
    chk(vout === 1'b0 && gray === to_gray(eb), "R7", {vout, gray[15:0]}, {1'b0, to_gray(eb)});
  endtask

  task automatic zero_press();
    if (zreq_n) pend_m = 1'b1;
    zreq_n = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic zero_release();
    zreq_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    int seed;
    seed = $urandom(32'd4711);
    repeat (3) @(negedge clk);
    chk(gray === '0 && vout === 1'b0, "R8", {vout, gray[15:0]}, '0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(gray === '0 && vout === 1'b0, "R8", {vout, gray[15:0]}, '0);
    apply(13'h0ABC, 4'h5, 1'b0, "R8");
    apply(13'h1FFF, 4'hF, 1'b0, "R1");
    apply(13'h1234, 4'h9, 1'b0, "R6");
    zero_press();
    apply(13'd100, 4'd3, 1'b0, "R2");
    apply(13'd150, 4'd7, 1'b0, "R3");
    apply(13'd0, 4'd0, 1'b0, "R9");
    apply(13'd99, 4'd3, 1'b0, "R9");
    apply(13'd200, 4'd1, 1'b0, "R4");
    zero_release();
    apply(13'd300, 4'd0, 1'b0, "R4");
    zero_press();
    apply(13'd0, 4'd1, 1'b0, "R2");
    apply(13'd0, 4'd0, 1'b0, "R9");
    apply(13'd5, 4'd1, 1'b1, "R5");
    apply(13'd0, 4'd1, 1'b1, "R5");
    apply(13'd0, 4'd0, 1'b1, "R5");
    zero_release();
    for (int i = 0; i < 300; i++) begin
      int r;
      r = $urandom_range(0, 15);
      if (r == 0) zero_press();
      else if (r == 1) zero_release();
      apply(13'($urandom()), 4'($urandom()), 1'($urandom()), "R3");
    end
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule